// File: doc/BRIEF.md
# Protection Region Configuration Register Bank

This block is the software-visible register bank of a memory protection unit. A CPU-side register bus (address, write enable, write data, read enable, read data) programs a global control word and, for each of up to sixteen protection regions, a base address, a size/enable/subregion word and an attribute word. The stored values are driven out as flat per-region arrays to the address-checking logic, which is a separate block.

Region storage is reached indirectly. A region-number register selects which region the base and size registers refer to. A base-register write may also carry its own region number, marked by a flag bit; this retargets the write and moves the selection to that region. Three alias windows repeat the base/size register pair at higher offsets so that software can program several regions in a burst. Each accepted write that can change a protection decision produces a one-cycle invalidate pulse for any cached lookups. Programming that is unpredictable or out of range sets a sticky error flag.

Top module: `mpu_regbank`

## Requirements
- R1: Offset 0xD90 is read-only. It reads NUM_REGIONS in bits [15:8] and zero elsewhere. Writes to it change nothing and produce no invalidate pulse.
- R2: Offset 0xD94 is the control word. It keeps only bit 0 (enable), bit 1 (keep checks on in high-priority handlers) and bit 2 (background map for privileged code). Other written bits are dropped and read as zero. The three bits drive ctrl_enable, ctrl_hiprio_on and ctrl_bgmap.
- R3: A control write with bit 1 set and bit 0 clear is still stored, and it sets the error flag.
- R4: Offset 0xD98 holds the selected region number. A write with a value below NUM_REGIONS is stored. A write with a value at or above NUM_REGIONS is ignored and sets the error flag.
- R5: A base write (offset 0xD9C) with bit 4 set targets the region in bits [3:0] and moves the selected region number to that value. If that region does not exist, the whole write is dropped, the selection stays unchanged and the error flag is set.
- R6: A base write with bit 4 clear targets the selected region. The stored base is the written word with bits [4:0] cleared.
- R7: A size write (offset 0xDA0) to the selected region stores bits [15:0] masked with 0xFF3F as the size word and bits [31:16] masked with 0x173F as the attribute word. A read returns the attribute word in [31:16] and the size word in [15:0].
- R8: A base read returns the stored base in bits [31:5], zero in bit 4 and the selected region number in bits [3:0].
- R9: The pairs 0xDA4/0xDA8, 0xDAC/0xDB0 and 0xDB4/0xDB8 act exactly as the base/size pair at 0xD9C/0xDA0, for both reads and writes.
- R10: inval_pulse is high for exactly the one cycle after each accepted control, base or size write. Region-number writes, read-only writes, dropped writes and unmapped writes do not raise it.
- R11: The error flag stays set until reset.
- R12: bus_rdata is registered. It shows the addressed word in the cycle after bus_rd, and zero after a cycle without bus_rd. When a read and a write happen in the same cycle, the read returns the value from before the write. Unmapped offsets read zero, and writes to them are ignored.
- R13: Reset clears the control word, the region number, every region's words, the error flag, the pulse and the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Register byte offset |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read enable |
| bus_rdata | output | 32 | Registered read data |
| ctrl_enable | output | 1 | Control bit 0 |
| ctrl_hiprio_on | output | 1 | Control bit 1 |
| ctrl_bgmap | output | 1 | Control bit 2 |
| rgn_base | output | NUM_REGIONS*32 | Region base words, region i at [i*32 +: 32] |
| rgn_size | output | NUM_REGIONS*16 | Size/enable/subregion words, region i at [i*16 +: 16] |
| rgn_attr | output | NUM_REGIONS*16 | Attribute words, region i at [i*16 +: 16] |
| inval_pulse | output | 1 | One-cycle flush request |
| prog_err | output | 1 | Sticky programming-error flag |

## Verification
A wrong region selection shows up at the ports in the cycle after the next base or size write: that write lands in the wrong slice of the region arrays. It also shows up in the cycle after any base read, through the region-number field of the read data. A wrongly masked or decoded field appears on the region arrays or the control outputs one cycle after the write. A missed or doubled error condition shows on the sticky flag in the cycle after the write that caused it. The bench keeps a behavioural model and compares every output, every region slice included, on every cycle, so any divergence is reported within one cycle of the write that caused it.

// File: rtl/mpu_regbank_pkg.sv
package mpu_regbank_pkg;

   localparam int unsigned ADDR_W = 12;
   localparam int unsigned DATA_W = 32;
   localparam int unsigned MAX_REGIONS = 16;
   localparam int unsigned MAX_ALIAS = 3;

   localparam logic [ADDR_W-1:0] OFF_INFO   = 12'hD90;
   localparam logic [ADDR_W-1:0] OFF_CTRL   = 12'hD94;
   localparam logic [ADDR_W-1:0] OFF_SELECT = 12'hD98;
   localparam logic [ADDR_W-1:0] OFF_BASE0  = 12'hD9C;
   localparam int unsigned       PAIR_STRIDE = 8;

   localparam logic [15:0] SIZE_KEEP = 16'hFF3F;
   localparam logic [15:0] ATTR_KEEP = 16'h173F;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_INFO,
      SEL_CTRL,
      SEL_SELECT,
      SEL_BASE,
      SEL_SIZE
   } reg_sel_e;

   typedef struct packed {
      logic bgmap;
      logic hiprio_on;
      logic enable;
   } ctrl_word_t;

endpackage

// File: rtl/mpu_addr_decode.sv
module mpu_addr_decode
   import mpu_regbank_pkg::*;
#(
   parameter int unsigned ALIAS_PAIRS = 3
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);

   localparam int unsigned NUM_PAIRS = ALIAS_PAIRS + 1;

   logic [NUM_PAIRS-1:0] hit_base;
   logic [NUM_PAIRS-1:0] hit_size;

   generate
      for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
         localparam logic [ADDR_W-1:0] PAIR_OFF = OFF_BASE0 + ADDR_W'(PAIR_STRIDE * k);
         assign hit_base[k] = (addr == PAIR_OFF);
         assign hit_size[k] = (addr == PAIR_OFF + ADDR_W'(4));
      end
   endgenerate

   always_comb begin
      sel = SEL_NONE;
      if (addr == OFF_INFO)        sel = SEL_INFO;
      else if (addr == OFF_CTRL)   sel = SEL_CTRL;
      else if (addr == OFF_SELECT) sel = SEL_SELECT;
      else if (|hit_base)          sel = SEL_BASE;
      else if (|hit_size)          sel = SEL_SIZE;
   end

   always_comb begin
      a_r9_window_exclusive: assert ($countones({hit_base, hit_size}) <= 1)
         else $error("R9: overlapping alias windows");
   end

endmodule

// File: rtl/mpu_region_slot.sv
module mpu_region_slot
   import mpu_regbank_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_we,
   input  logic              size_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [31:0]       base,
   output logic [15:0]       size,
   output logic [15:0]       attr
);

   logic [26:0] base_q;
   logic [15:0] size_q;
   logic [15:0] attr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
      end else if (base_we) begin
         base_q <= wdata[31:5];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         size_q <= '0;
         attr_q <= '0;
      end else if (size_we) begin
         size_q <= wdata[15:0] & SIZE_KEEP;
         attr_q <= wdata[31:16] & ATTR_KEEP;
      end
   end

   assign base = {base_q, 5'b0};
   assign size = size_q;
   assign attr = attr_q;

   a_r7_size_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ((size & ~SIZE_KEEP) == 16'h0) && ((attr & ~ATTR_KEEP) == 16'h0))
      else $error("R7: reserved size/attribute bits set");

   a_r6_base_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
      base_we |=> (base[4:0] == 5'h0) && (base[31:5] == $past(wdata[31:5])))
      else $error("R6: stored base wrong");

endmodule

// File: rtl/mpu_read_mux.sv
module mpu_read_mux
   import mpu_regbank_pkg::*;
#(
   parameter int unsigned NUM_REGIONS = 8
) (
   input  reg_sel_e                   sel,
   input  logic [3:0]                 rnr,
   input  ctrl_word_t                 ctrl,
   input  logic [NUM_REGIONS*32-1:0]  base_flat,
   input  logic [NUM_REGIONS*16-1:0]  size_flat,
   input  logic [NUM_REGIONS*16-1:0]  attr_flat,
   output logic [DATA_W-1:0]          rd_word
);

   logic [31:0] cur_base;
   logic [15:0] cur_size;
   logic [15:0] cur_attr;

   always_comb begin
      cur_base = '0;
      cur_size = '0;
      cur_attr = '0;
      for (int i = 0; i < int'(NUM_REGIONS); i++) begin
         if (int'(rnr) == i) begin
            cur_base = base_flat[i*32 +: 32];
            cur_size = size_flat[i*16 +: 16];
            cur_attr = attr_flat[i*16 +: 16];
         end
      end
   end

   always_comb begin
      unique case (sel)
         SEL_INFO:   rd_word = {16'h0, 8'(NUM_REGIONS), 8'h0};
         SEL_CTRL:   rd_word = {29'h0, ctrl};
         SEL_SELECT: rd_word = {28'h0, rnr};
         SEL_BASE:   rd_word = {cur_base[31:5], 1'b0, rnr};
         SEL_SIZE:   rd_word = {cur_attr, cur_size};
         default:    rd_word = '0;
      endcase
   end

endmodule

// File: rtl/mpu_regbank.sv
module mpu_regbank
   import mpu_regbank_pkg::*;
#(
   parameter int unsigned NUM_REGIONS = 8,
   parameter int unsigned ALIAS_PAIRS = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [11:0]                bus_addr,
   input  logic                       bus_wr,
   input  logic [31:0]                bus_wdata,
   input  logic                       bus_rd,
   output logic [31:0]                bus_rdata,
   output logic                       ctrl_enable,
   output logic                       ctrl_hiprio_on,
   output logic                       ctrl_bgmap,
   output logic [NUM_REGIONS*32-1:0]  rgn_base,
   output logic [NUM_REGIONS*16-1:0]  rgn_size,
   output logic [NUM_REGIONS*16-1:0]  rgn_attr,
   output logic                       inval_pulse,
   output logic                       prog_err
);

   localparam logic [4:0]  NREG5  = 5'(NUM_REGIONS);
   localparam logic [31:0] NREG32 = 32'(NUM_REGIONS);

   generate
      if (NUM_REGIONS < 1 || NUM_REGIONS > MAX_REGIONS) begin : g_bad_regions
         $error("NUM_REGIONS must be 1..16");
      end
      if (ALIAS_PAIRS > MAX_ALIAS) begin : g_bad_alias
         $error("ALIAS_PAIRS must be 0..3");
      end
   endgenerate

   reg_sel_e   sel;
   ctrl_word_t ctrl_q;
   logic [3:0] rnr_q;
   logic       err_q;
   logic       inval_q;
   logic [31:0] rdata_q;
   logic [DATA_W-1:0] rd_word;

   mpu_addr_decode #(.ALIAS_PAIRS(ALIAS_PAIRS)) u_decode (
      .addr (bus_addr),
      .sel  (sel)
   );

   // write qualification
   logic       flag_retarget;
   logic [3:0] base_target;
   logic       base_in_range;
   logic       sel_in_range;
   logic       wr_ctrl, wr_select, wr_base, wr_size;
   logic       select_ok, base_ok, size_ok;
   logic       ctrl_bad, err_set, accepted;

   always_comb begin
      flag_retarget = bus_wdata[4];
      base_target   = flag_retarget ? bus_wdata[3:0] : rnr_q;
      base_in_range = ({1'b0, base_target} < NREG5);
      sel_in_range  = ({1'b0, rnr_q} < NREG5);

      wr_ctrl   = bus_wr && (sel == SEL_CTRL);
      wr_select = bus_wr && (sel == SEL_SELECT);
      wr_base   = bus_wr && (sel == SEL_BASE);
      wr_size   = bus_wr && (sel == SEL_SIZE);

      select_ok = wr_select && (bus_wdata < NREG32);
      base_ok   = wr_base && base_in_range;
      size_ok   = wr_size && sel_in_range;

      ctrl_bad  = wr_ctrl && bus_wdata[1] && !bus_wdata[0];
      err_set   = ctrl_bad
                || (wr_select && !select_ok)
                || (wr_base && !base_in_range);
      accepted  = wr_ctrl || base_ok || size_ok;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_ctrl) begin
         ctrl_q <= ctrl_word_t'(bus_wdata[2:0]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rnr_q <= '0;
      end else if (select_ok) begin
         rnr_q <= bus_wdata[3:0];
      end else if (base_ok && flag_retarget) begin
         rnr_q <= base_target;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q   <= 1'b0;
         inval_q <= 1'b0;
      end else begin
         err_q   <= err_q | err_set;
         inval_q <= accepted;
      end
   end

   // per-region storage
   generate
      for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_slot
         logic base_we_i, size_we_i;
         assign base_we_i = base_ok && (base_target == 4'(i));
         assign size_we_i = size_ok && (rnr_q == 4'(i));
         mpu_region_slot u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .base_we (base_we_i),
            .size_we (size_we_i),
            .wdata   (bus_wdata),
            .base    (rgn_base[i*32 +: 32]),
            .size    (rgn_size[i*16 +: 16]),
            .attr    (rgn_attr[i*16 +: 16])
         );
      end
   endgenerate

   mpu_read_mux #(.NUM_REGIONS(NUM_REGIONS)) u_rmux (
      .sel       (sel),
      .rnr       (rnr_q),
      .ctrl      (ctrl_q),
      .base_flat (rgn_base),
      .size_flat (rgn_size),
      .attr_flat (rgn_attr),
      .rd_word   (rd_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else begin
         rdata_q <= bus_rd ? rd_word : '0;
      end
   end

   assign bus_rdata      = rdata_q;
   assign ctrl_enable    = ctrl_q.enable;
   assign ctrl_hiprio_on = ctrl_q.hiprio_on;
   assign ctrl_bgmap     = ctrl_q.bgmap;
   assign inval_pulse    = inval_q;
   assign prog_err       = err_q;

   a_r4_select_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, rnr_q} < NREG5)
      else $error("R4: region number out of range");

   a_r10_pulse_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      inval_pulse |-> $past(bus_wr) && ($past(sel) inside {SEL_CTRL, SEL_BASE, SEL_SIZE}))
      else $error("R10: invalidate without accepted write");

   a_r1_info_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel == SEL_INFO) |=> !inval_pulse && !$changed(ctrl_q))
      else $error("R1: read-only write had an effect");

   a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      prog_err |=> prog_err)
      else $error("R11: error flag cleared");

   a_r5_retarget_moves_select: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_base && flag_retarget && base_in_range) |=> rnr_q == $past(bus_wdata[3:0]))
      else $error("R5: selection not retargeted");

   a_r12_rdata_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> bus_rdata == 32'h0)
      else $error("R12: read data not zero when idle");

endmodule

// File: tb/mpu_regbank_tb.sv
module mpu_regbank_tb;

   localparam int N = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [11:0]       bus_addr = '0;
   logic              bus_wr = 1'b0;
   logic [31:0]       bus_wdata = '0;
   logic              bus_rd = 1'b0;
   logic [31:0]       bus_rdata;
   logic              ctrl_enable, ctrl_hiprio_on, ctrl_bgmap;
   logic [N*32-1:0]   rgn_base;
   logic [N*16-1:0]   rgn_size;
   logic [N*16-1:0]   rgn_attr;
   logic              inval_pulse, prog_err;

   always #5 clk = ~clk;

   mpu_regbank #(.NUM_REGIONS(N), .ALIAS_PAIRS(3)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .ctrl_enable(ctrl_enable), .ctrl_hiprio_on(ctrl_hiprio_on),
      .ctrl_bgmap(ctrl_bgmap), .rgn_base(rgn_base), .rgn_size(rgn_size),
      .rgn_attr(rgn_attr), .inval_pulse(inval_pulse), .prog_err(prog_err)
   );

   int n_checks = 0;
   int n_fails = 0;
   bit done = 0;

   // behavioural model
   int unsigned m_ctrl, m_sel;
   int unsigned m_base[N], m_size[N], m_attr[N];
   bit m_err, m_inval;
   int unsigned m_rdata;

   task automatic model_clear();
      m_ctrl = 0; m_sel = 0; m_err = 0; m_inval = 0; m_rdata = 0;
      for (int i = 0; i < N; i++) begin
         m_base[i] = 0; m_size[i] = 0; m_attr[i] = 0;
      end
   endtask

   function automatic int kind(input int unsigned a);
      if (a == 'hD90) return 1;
      if (a == 'hD94) return 2;
      if (a == 'hD98) return 3;
      if (a == 'hD9C || a == 'hDA4 || a == 'hDAC || a == 'hDB4) return 4;
      if (a == 'hDA0 || a == 'hDA8 || a == 'hDB0 || a == 'hDB8) return 5;
      return 0;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic compare_all(input string tag);
      chk({tag, " rdata"}, bus_rdata, m_rdata);
      chk({tag, " inval"}, {31'h0, inval_pulse}, {31'h0, m_inval});
      chk({tag, " err"}, {31'h0, prog_err}, {31'h0, m_err});
      chk({tag, " ctrl"}, {29'h0, ctrl_bgmap, ctrl_hiprio_on, ctrl_enable}, m_ctrl);
      for (int i = 0; i < N; i++) begin
         chk({tag, " base"}, rgn_base[i*32 +: 32], m_base[i]);
         chk({tag, " size"}, {16'h0, rgn_size[i*16 +: 16]}, m_size[i]);
         chk({tag, " attr"}, {16'h0, rgn_attr[i*16 +: 16]}, m_attr[i]);
      end
   endtask

   // one bus cycle: drive at negedge, model the edge, compare at next negedge
   task automatic op(input string tag, input bit wr, input bit rd,
                     input int unsigned addr, input int unsigned data);
      int k;
      int unsigned tgt;
      bit acc;
      bus_addr = 12'(addr); bus_wr = wr; bus_rd = rd; bus_wdata = data;
      k = kind(addr);
      m_rdata = 0;
      if (rd) begin
         case (k)
            1: m_rdata = N << 8;
            2: m_rdata = m_ctrl;
            3: m_rdata = m_sel;
            4: m_rdata = (m_base[m_sel] & 32'hFFFF_FFE0) | m_sel;
            5: m_rdata = (m_attr[m_sel] << 16) | m_size[m_sel];
            default: m_rdata = 0;
         endcase
      end
      acc = 0;
      if (wr) begin
         case (k)
            2: begin
               m_ctrl = data & 7; acc = 1;
               if (((data >> 1) & 1) == 1 && (data & 1) == 0) m_err = 1;
            end
            3: if (data < N) m_sel = data; else m_err = 1;
            4: begin
               if ((data >> 4) & 1) tgt = data & 15; else tgt = m_sel;
               if (tgt < N) begin
                  m_base[tgt] = data & 32'hFFFF_FFE0;
                  m_sel = tgt; acc = 1;
               end else m_err = 1;
            end
            5: begin
               m_size[m_sel] = data & 32'h0000_FF3F;
               m_attr[m_sel] = (data >> 16) & 32'h0000_173F;
               acc = 1;
            end
            default: ;
         endcase
      end
      m_inval = acc;
      @(negedge clk);
      compare_all(tag);
      bus_wr = 0; bus_rd = 0;
   endtask

   task automatic do_reset();
      bus_wr = 0; bus_rd = 0;
      rst_n = 0;
      repeat (2) @(negedge clk);
      model_clear();
      rst_n = 1;
      @(negedge clk);
      compare_all("R13 reset");
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      model_clear();
      @(negedge clk);
      do_reset();

      // R1: read-only info register
      op("R1 info read", 0, 1, 'hD90, 0);
      op("R1 info write", 1, 0, 'hD90, 'hFFFF_FFFF);
      op("R1 info reread", 0, 1, 'hD90, 0);
      // R2: control masking
      op("R2 ctrl write", 1, 0, 'hD94, 'hFFFF_FFFD);
      op("R2 ctrl read", 0, 1, 'hD94, 0);
      // R3: unpredictable combination
      op("R3 ctrl bad", 1, 0, 'hD94, 2);
      op("R3 ctrl read", 0, 1, 'hD94, 0);
      op("R11 err sticky", 0, 0, 'hD94, 0);
      op("R11 err sticky2", 1, 0, 'hD94, 1);

      do_reset();
      // R4: region select
      op("R4 sel write", 1, 0, 'hD98, 5);
      op("R4 sel read", 0, 1, 'hD98, 0);
      op("R4 sel bad", 1, 0, 'hD98, N);
      op("R4 sel unchanged", 0, 1, 'hD98, 0);

      do_reset();
      // R6: base via current selection
      op("R6 base write", 1, 0, 'hD9C, 'h2000_00EF);
      op("R8 base read", 0, 1, 'hD9C, 0);
      // R5: retargeting base write
      op("R5 retarget", 1, 0, 'hD9C, 'h4000_0013);
      op("R8 base read rgn3", 0, 1, 'hD9C, 0);
      op("R5 sel follows", 0, 1, 'hD98, 0);
      op("R5 retarget bad", 1, 0, 'hD9C, 'h8000_001A);
      op("R5 sel kept", 0, 1, 'hD98, 0);

      do_reset();
      // R7: size/attribute masks
      op("R7 sel", 1, 0, 'hD98, 2);
      op("R7 size write", 1, 0, 'hDA0, 'hFFFF_FFFF);
      op("R7 size read", 0, 1, 'hDA0, 0);
      // R9: alias windows
      op("R9 alias base", 1, 0, 'hDAC, 'h1234_5616);
      op("R9 alias size", 1, 0, 'hDB8, 'h0005_0023);
      op("R9 alias read size", 0, 1, 'hDA8, 0);
      op("R9 alias read base", 0, 1, 'hDB4, 0);
      op("R9 alias a1 base", 1, 1, 'hDA4, 'hABCD_0011);
      op("R9 alias a2 size", 1, 1, 'hDB0, 'h1234_5678);
      // R12: unmapped and read-during-write
      op("R12 unmapped read", 0, 1, 'hDBC, 0);
      op("R12 unmapped write", 1, 0, 'hDC0, 'hFFFF_FFFF);
      op("R12 idle", 0, 0, 'hD90, 0);
      op("R12 rd+wr", 1, 1, 'hD98, 4);
      op("R10 sel no pulse", 1, 0, 'hD98, 1);

      // R10: mixed traffic, compared every cycle
      for (int t = 0; t < 300; t++) begin
         int unsigned a;
         int unsigned d;
         a = 'hD90 + 4 * ($urandom % 12);
         d = $urandom;
         if ((t % 5) == 0) d = d & 'hFFFF_FF17;
         if ((t % 7) == 0 && kind(a) == 3) d = d % 10;
         op("R10 mixed", ($urandom % 2) == 1, ($urandom % 2) == 1, a, d);
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

endmodule